// File: doc/BRIEF.md
# Chained Two-Channel Free-Running Counter

This block builds a wide free-running count out of two narrow counter channels. Channel 0 advances on a qualified count tick. It also drives a waveform output that rises when its count reaches zero and falls when it reaches the midpoint. The result is a square wave with a 50% duty cycle and one rising edge per full lap of the low channel. Channel 1 takes its count clock from a selectable source. When that source is channel 0's waveform, channel 1 counts laps and the pair forms one counter of twice the channel width. The other source is a plain external tick input.

Both channels stay in the master clock domain. Channel 1 detects rising edges of its selected source synchronously, which adds a fixed one-cycle delay to every carry. Software therefore reads the wide value as upper half, lower half, then upper half again, and repeats the read if the two upper readings differ. A block-wide sync command clears every channel, the waveform and the edge detector in the same cycle. A build parameter swaps the chained pair for a single channel of full width, which gives the same wide count with no carry delay.

Top module: `chained_timer_pair`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), count_lo, count_hi and wave0 are all 0.
- R2: count_lo rises by exactly 1 at every clock edge where cnt_tick is 1 and sync_req is 0, stays unchanged when cnt_tick is 0, and wraps from all ones to 0.
- R3: wave0 changes only at ticking edges. It becomes 1 when count_lo advances to 0 and becomes 0 when count_lo advances to half its range (bit HALF_W-1 set, all others clear). After a sync, wave0 stays 0 until the next wrap of count_lo.
- R4: With ch1_src = 1 (channel 0 waveform), count_hi rises by exactly 1 for each rising edge of wave0, one clock after wave0 rises, and at no other time.
- R5: With ch1_src = 0 (external source), count_hi rises by 1 at each clock edge where ext_tick is 1 and was 0 at the previous edge. wave0 edges then have no effect on count_hi.
- R6: An edge with sync_req = 1 clears count_lo, count_hi, wave0 and any pending carry, taking priority over cnt_tick.
- R7: In chained mode with ch1_src = 1 since the last sync, reading count_hi, then count_lo, then count_hi on three consecutive cycles, and retrying while the two upper readings differ, yields {count_hi, count_lo} equal to the number of ticks counted at the lower read.
- R8: With WIDE = 1, a single channel of 2*HALF_W bits supplies {count_hi, count_lo}, equal at every cycle to the ticks counted since reset or sync, with no carry delay. ch1_src and ext_tick have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_tick | input | 1 | Count qualifier for channel 0 |
| sync_req | input | 1 | Block-wide synchronous clear of all channels |
| ch1_src | input | 1 | Channel 1 clock source: 1 = channel 0 waveform, 0 = ext_tick |
| ext_tick | input | 1 | External clock source for channel 1 (rising edge counted) |
| count_lo | output | HALF_W | Lower half of the wide count (channel 0) |
| count_hi | output | HALF_W | Upper half of the wide count (channel 1, or top of the single channel) |
| wave0 | output | 1 | Channel 0 square-wave output |

## Verification
A wrong low count shows on count_lo at the next clock edge and stays wrong from then on. A bad compare value or waveform register shows only at the next zero or midpoint crossing. On count_hi it appears as a missing or extra carry after a full lap of 65536 ticks, so the bench runs two complete laps. A stale or uncleared edge detector shows as a double or missing increment of count_hi one clock after its source rises, or right after a sync. The three-read retry is exercised around a wrap to expose the carry delay.

// File: rtl/cascade_pkg.sv
// Shared types for the chained counter pair.
// Assumes: nothing beyond the 1800-2017 language.
package cascade_pkg;

    // Clock source selection for channel 1
    typedef enum logic {
        SRC_EXT = 1'b0,
        SRC_CH0 = 1'b1
    } clk1_src_e;

endpackage

// File: rtl/ctr_channel.sv
// Plain up counter of parameterised width with a synchronous clear.
// Assumes: clr has priority over inc; counts wrap modulo 2**W.
module ctr_channel #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);

    // Count register: clear on reset or clear request, else advance on inc
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count <= '0;
        end else if (inc) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/wave_gen.sv
// Compare-driven waveform for a counter channel: goes high when the
// counter advances to SET_AT, low when it advances to CLR_AT.
// Assumes: adv is the same qualifier that advances the counter, so the
// compare looks at the value the counter is about to take.
module wave_gen #(
    parameter int W = 16,
    parameter logic [W-1:0] SET_AT = '0,
    parameter logic [W-1:0] CLR_AT = {1'b1, {(W-1){1'b0}}}
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         adv,
    input  logic [W-1:0] count,
    output logic         wave
);

    logic [W-1:0] next_val;

    // Value the counter takes on this ticking edge
    assign next_val = count + 1'b1;

    // Waveform register: set/clear on compare matches at ticking edges only
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wave <= 1'b0;
        end else if (adv) begin
            if (next_val == SET_AT) begin
                wave <= 1'b1;
            end else if (next_val == CLR_AT) begin
                wave <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/rise_det.sv
// Synchronous rising-edge detector in the master clock domain.
// Assumes: sig is already synchronous to clk; rise is combinational
// from sig and a one-cycle history register cleared by clr.
module rise_det (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic sig,
    output logic rise
);

    logic sig_d;

    // History register for the previous sampled level
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            sig_d <= 1'b0;
        end else begin
            sig_d <= sig;
        end
    end

    // Edge pulse: high while sig is high after being low at the last edge
    assign rise = sig & ~sig_d;

endmodule

// File: rtl/chained_timer_pair.sv
// Two counter channels chained into one wide free-running counter.
// Channel 0 counts cnt_tick and drives a 50% square wave; channel 1
// counts rising edges of either that wave or ext_tick. With WIDE set,
// a single channel of twice the width replaces the pair.
// Assumes: ch1_src is changed only while both candidate sources are low.
module chained_timer_pair
    import cascade_pkg::*;
#(
    parameter int HALF_W = 16,
    parameter bit WIDE   = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_tick,
    input  logic              sync_req,
    input  logic              ch1_src,
    input  logic              ext_tick,
    output logic [HALF_W-1:0] count_lo,
    output logic [HALF_W-1:0] count_hi,
    output logic              wave0
);

    localparam int                FULL_W = 2 * HALF_W;
    localparam logic [HALF_W-1:0] SET_AT = '0;
    localparam logic [HALF_W-1:0] CLR_AT = {1'b1, {(HALF_W-1){1'b0}}};

    generate
        if (WIDE) begin : g_single
            logic [FULL_W-1:0] full_cnt;

            // One channel holds the whole count
            ctr_channel #(.W(FULL_W)) u_ch0 (
                .clk   (clk),
                .rst_n (rst_n),
                .clr   (sync_req),
                .inc   (cnt_tick),
                .count (full_cnt)
            );

            // Waveform still follows the lower half
            wave_gen #(.W(HALF_W), .SET_AT(SET_AT), .CLR_AT(CLR_AT)) u_wave (
                .clk   (clk),
                .rst_n (rst_n),
                .clr   (sync_req),
                .adv   (cnt_tick),
                .count (full_cnt[HALF_W-1:0]),
                .wave  (wave0)
            );

            assign count_lo = full_cnt[HALF_W-1:0];
            assign count_hi = full_cnt[FULL_W-1:HALF_W];
        end else begin : g_chain
            logic src_sig;
            logic src_rise;

            // Channel 0: low half
            ctr_channel #(.W(HALF_W)) u_ch0 (
                .clk   (clk),
                .rst_n (rst_n),
                .clr   (sync_req),
                .inc   (cnt_tick),
                .count (count_lo)
            );

            // Channel 0 square wave: rises on wrap, falls at midpoint
            wave_gen #(.W(HALF_W), .SET_AT(SET_AT), .CLR_AT(CLR_AT)) u_wave (
                .clk   (clk),
                .rst_n (rst_n),
                .clr   (sync_req),
                .adv   (cnt_tick),
                .count (count_lo),
                .wave  (wave0)
            );

            // Channel 1 source select
            assign src_sig = (clk1_src_e'(ch1_src) == SRC_CH0) ? wave0 : ext_tick;

            // Edge detect of the selected source
            rise_det u_edge (
                .clk   (clk),
                .rst_n (rst_n),
                .clr   (sync_req),
                .sig   (src_sig),
                .rise  (src_rise)
            );

            // Channel 1: high half, one count per source edge
            ctr_channel #(.W(HALF_W)) u_ch1 (
                .clk   (clk),
                .rst_n (rst_n),
                .clr   (sync_req),
                .inc   (src_rise),
                .count (count_hi)
            );
        end
    endgenerate

endmodule

// File: rtl/chained_timer_pair_chk.sv
// Port-level assertions for chained_timer_pair, attached by bind.
// Assumes: observes only the top-level ports.
module chained_timer_pair_chk #(
    parameter int HALF_W = 16,
    parameter bit WIDE   = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cnt_tick,
    input logic              sync_req,
    input logic              ch1_src,
    input logic              ext_tick,
    input logic [HALF_W-1:0] count_lo,
    input logic [HALF_W-1:0] count_hi,
    input logic              wave0
);

    // R1
    lo_reset_chk: assert property (@(posedge clk)
        !rst_n |=> (count_lo == '0 && count_hi == '0 && !wave0));

    // R2
    lo_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_tick && !sync_req) |=> (count_lo == $past(count_lo) + 1'b1));

    // R2
    lo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_tick && !sync_req) |=> $stable(count_lo));

    // R3
    wave_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_tick && !sync_req) |=> $stable(wave0));

    // R3
    wave_rise_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wave0) |-> (count_lo == '0));

    // R6
    sync_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_req |=> (count_lo == '0 && count_hi == '0 && !wave0));

    generate
        if (!WIDE) begin : g_chain_chk
            // R4
            carry_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ($rose(wave0) && ch1_src && $past(ch1_src) && !sync_req)
                |=> (count_hi == $past(count_hi) + 1'b1));

            // R5
            ext_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ($rose(ext_tick) && !ch1_src && $past(!ch1_src)
                 && !sync_req && !$past(sync_req))
                |=> (count_hi == $past(count_hi) + 1'b1));
        end
    endgenerate

endmodule

bind chained_timer_pair chained_timer_pair_chk #(.HALF_W(HALF_W), .WIDE(WIDE)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_tick (cnt_tick),
    .sync_req (sync_req),
    .ch1_src  (ch1_src),
    .ext_tick (ext_tick),
    .count_lo (count_lo),
    .count_hi (count_hi),
    .wave0    (wave0)
);

// File: tb/test_chained_timer_pair.sv
module test_chained_timer_pair;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_tick = 1'b0;
    logic        sync_req = 1'b0;
    logic        ch1_src = 1'b1;
    logic        ext_tick = 1'b0;
    logic [15:0] count_lo, count_hi, w_lo, w_hi;
    logic        wave0, w_wave;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit running = 1'b0;

    // Behavioural reference state
    logic [15:0] m_lo = '0, m_hi = '0;
    logic [31:0] m_ref = '0;
    bit          m_pend = 0, m_wrapped = 0, m_ext_prev = 0;

    always #2 clk = ~clk;

    chained_timer_pair i_chained_timer_pair (
        .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .sync_req(sync_req),
        .ch1_src(ch1_src), .ext_tick(ext_tick),
        .count_lo(count_lo), .count_hi(count_hi), .wave0(wave0));

    chained_timer_pair #(.HALF_W(16), .WIDE(1'b1)) i_wide_pair (
        .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .sync_req(sync_req),
        .ch1_src(ch1_src), .ext_tick(ext_tick),
        .count_lo(w_lo), .count_hi(w_hi), .wave0(w_wave));

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic wrap_up;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // Reference model: carries land one edge after the low wrap
    always @(posedge clk) begin
        if (!rst_n || sync_req) begin
            m_lo = '0; m_hi = '0; m_ref = '0;
            m_pend = 0; m_wrapped = 0; m_ext_prev = 0;
        end else begin
            if (ch1_src) begin
                if (m_pend) m_hi = m_hi + 16'd1;
            end else begin
                if (ext_tick && !m_ext_prev) m_hi = m_hi + 16'd1;
            end
            m_ext_prev = ext_tick;
            m_pend = cnt_tick && (m_lo == 16'hFFFF);
            if (cnt_tick) begin
                m_lo  = m_lo + 16'd1;
                m_ref = m_ref + 32'd1;
                if (m_lo == 16'h0000) m_wrapped = 1;
            end
        end
    end

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && running) begin
            chk(count_lo == m_lo, "R2 low count", {16'h0, count_lo}, {16'h0, m_lo});
            chk(wave0 == (m_wrapped && m_lo < 16'h8000), "R3 waveform",
                {31'h0, wave0}, {31'h0, (m_wrapped && m_lo < 16'h8000)});
            chk(count_hi == m_hi, ch1_src ? "R4 carry count" : "R5 external count",
                {16'h0, count_hi}, {16'h0, m_hi});
            chk({w_hi, w_lo} == m_ref, "R8 single wide channel", {w_hi, w_lo}, m_ref);
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc == 190000) begin
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, 190000);
            wrap_up();
        end
    end

    // R7: upper, lower, upper read with retry
    task automatic read32(output logic [31:0] val, output logic [31:0] ref_at);
        logic [15:0] h1, l, h2;
        forever begin
            @(negedge clk) h1 = count_hi;
            @(negedge clk) begin l = count_lo; ref_at = m_ref; end
            @(negedge clk) h2 = count_hi;
            if (h1 == h2) break;
        end
        val = {h2, l};
    endtask

    initial begin
        logic [31:0] rv, rr;
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(count_lo == 0 && count_hi == 0 && wave0 == 0, "R1 reset",
            {count_hi, count_lo}, 32'h0);
        chk({w_hi, w_lo} == 0, "R1 reset wide", {w_hi, w_lo}, 32'h0);
        rst_n = 1'b1;
        running = 1'b1;

        // Irregular ticks, carries from channel 0
        for (int i = 0; i < 600; i++) begin
            @(negedge clk) cnt_tick = 1'($urandom % 2);
        end

        // R6: sync while ticking
        @(negedge clk) begin cnt_tick = 1'b1; sync_req = 1'b1; end
        @(negedge clk) sync_req = 1'b0;
        chk(count_lo == 0 && count_hi == 0 && wave0 == 0, "R6 sync clear",
            {count_hi, count_lo}, 32'h0);
        chk({w_hi, w_lo} == 0, "R6 sync clear wide", {w_hi, w_lo}, 32'h0);

        // Run to just before the first wrap, then read across it
        while (m_lo != 16'hFFF6) @(negedge clk);
        for (int k = 0; k < 6; k++) begin
            read32(rv, rr);
            chk(rv == rr, "R7 retry read", rv, rr);
        end
        chk(count_hi == 16'd1, "R4 first carry", {16'h0, count_hi}, 32'd1);

        // Second lap: switch to the external source while wave0 is low
        while (m_lo != 16'hF000) @(negedge clk);
        @(negedge clk) ch1_src = 1'b0;
        for (int i = 0; i < 8000; i++) begin
            @(negedge clk) ext_tick = ((i % 6) < 3);
        end
        chk(count_hi == 16'd1 + 16'd1334, "R5 ext edges only",
            {16'h0, count_hi}, 32'd1335);
        @(negedge clk) ext_tick = 1'b0;

        // R6: sync clears and restarts in external mode
        @(negedge clk) sync_req = 1'b1;
        @(negedge clk) sync_req = 1'b0;
        chk(count_hi == 0 && count_lo == 0, "R6 sync after ext",
            {count_hi, count_lo}, 32'h0);
        repeat (20) @(negedge clk);

        running = 1'b0;
        wrap_up();
    end

endmodule